// File: doc/BRIEF.md
# Banked EEPROM Address Pointer

This block keeps the byte address pointer and the bank selection for a 4-Kbit serial EEPROM. The array is split into two 256-byte halves, and only one half can be reached at a time. The pointer is 8 bits wide and always addresses the selected half. The bank bit sits above the pointer to form the 9-bit array address.

The serial-bus front end drives the block through single-cycle strobes:

- load a new byte address;
- advance the pointer after a data byte has been sent;
- select the lower bank;
- select the upper bank;
- ask which bank is in use.

The front end and the array itself sit outside this block. Sequential reads wrap inside the selected half, never into the other one. The bank can be changed at any time without a reset.

All pins are plain control and status lines. No data stream crosses this block, so it has no valid/ready handshake. The query answer is a one-cycle valid pulse with the bank value beside it. It has no back-pressure: the front end must take it in the cycle it appears.

Top module: `eeprom_bank_ptr`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the outputs are as follows: `arr_addr` is 0x000, `bank_act` is 0 (lower bank), and `qry_vld` is 0.
- R2: A cycle with `sel_hi` high and `sel_lo` low makes `bank_act` 1 from the next clock edge. The pointer, which is `arr_addr[7:0]`, keeps its value.
- R3: A cycle with `sel_lo` high and `sel_hi` low makes `bank_act` 0 from the next clock edge, with no reset needed. The pointer keeps its value.
- R4: A cycle with both `sel_lo` and `sel_hi` high leaves the bank unchanged.
- R5: A cycle with `qry_stb` high makes `qry_vld` 1 for exactly the following cycle. In that cycle, `qry_bank` equals the bank in effect after the same edge, including any bank command given in the query cycle. When no query is made, `qry_vld` stays 0.
- R6: A cycle with `inc_stb` high and `ld_stb` low adds one to the pointer at the next edge.
- R7: Incrementing from pointer 0xFF gives 0x00, and `arr_addr[8]` is unchanged. Reads wrap inside the active bank.
- R8: `ld_stb` replaces the pointer with `ld_val` and leaves the bank unchanged. When `ld_stb` and `inc_stb` are high in the same cycle, the loaded value wins.
- R9: When a bank command and `inc_stb` are high in the same cycle, both apply: the bank changes and the pointer increments.
- R10: `arr_addr` is always `{bank_act, pointer}`. Bit 8 is the bank and bits 7:0 are the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ld_stb | input | 1 | Load the pointer from `ld_val` |
| ld_val | input | 8 | New byte address |
| inc_stb | input | 1 | Advance the pointer after a byte is read |
| sel_lo | input | 1 | Select the lower bank |
| sel_hi | input | 1 | Select the upper bank |
| qry_stb | input | 1 | Ask which bank is active |
| arr_addr | output | 9 | Array address: bank bit above the pointer |
| bank_act | output | 1 | Active bank: 0 is lower, 1 is upper |
| qry_vld | output | 1 | One-cycle pulse answering a query |
| qry_bank | output | 1 | Bank reported with `qry_vld` |

## Verification
The pointer is tested with three kinds of input:

- Runs of increments, which show that counting works.
- Loads near the top of a bank followed by increments. These separate a wrap kept inside the bank from one that carries into bit 8, in both halves.
- Loads given in the same cycle as an increment, which show which of the two has priority.

Bank commands are given alone, both at once, and in the same cycle as an increment or a query. This shows whether the pointer is left alone and whether the query reports the bank value after that edge rather than the one before it.

// File: rtl/bank_ptr_pkg.sv
package bank_ptr_pkg;
  typedef enum logic [1:0] {
    BK_KEEP  = 2'd0,
    BK_LOWER = 2'd1,
    BK_UPPER = 2'd2
  } bank_op_e;

  // Conflicting commands collapse to a hold.
  function automatic bank_op_e bank_decode(input logic lo, input logic hi);
    if (lo && !hi) return BK_LOWER;
    if (hi && !lo) return BK_UPPER;
    return BK_KEEP;
  endfunction
endpackage

// File: rtl/bp_offset_ctr.sv
module bp_offset_ctr #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [PTR_W-1:0] ld_val,
  input  logic             inc,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (ld)  ptr <= ld_val;
    else if (inc) ptr <= ptr + ONE;
  end

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> ptr == $past(ld_val)); // R8
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld && !(&ptr)) |=> ptr > $past(ptr)); // R6
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld && (&ptr)) |=> ptr == '0); // R7
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !ld) |=> $stable(ptr)); // R2
endmodule

// File: rtl/bp_bank_flag.sv
module bp_bank_flag
  import bank_ptr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lo,
  input  logic hi,
  input  logic qry,
  output logic bank,
  output logic qry_vld,
  output logic qry_bank
);
  bank_op_e op;
  logic     bank_nxt;

  always_comb begin
    op = bank_decode(lo, hi);
    unique case (op)
      BK_LOWER: bank_nxt = 1'b0;
      BK_UPPER: bank_nxt = 1'b1;
      default:  bank_nxt = bank;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank     <= 1'b0;
      qry_vld  <= 1'b0;
      qry_bank <= 1'b0;
    end else begin
      bank    <= bank_nxt;
      qry_vld <= qry;
      if (qry) qry_bank <= bank_nxt;
    end
  end

  AST_BANK_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (hi && !lo) |=> bank); // R2
  AST_BANK_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    (lo && !hi) |=> !bank); // R3
  AST_BANK_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    (lo == hi) |=> $stable(bank)); // R4
  AST_QRY_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    qry |=> (qry_vld && qry_bank == bank)); // R5
  AST_QRY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !qry |=> !qry_vld); // R5
endmodule

// File: rtl/eeprom_bank_ptr.sv
module eeprom_bank_ptr #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_stb,
  input  logic [PTR_W-1:0] ld_val,
  input  logic             inc_stb,
  input  logic             sel_lo,
  input  logic             sel_hi,
  input  logic             qry_stb,
  output logic [PTR_W:0]   arr_addr,
  output logic             bank_act,
  output logic             qry_vld,
  output logic             qry_bank
);
  localparam int ADDR_W = PTR_W + 1;

  logic [PTR_W-1:0] ptr;
  logic [ADDR_W-1:0] addr_w;

  bp_offset_ctr #(.PTR_W(PTR_W)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (ld_stb),
    .ld_val (ld_val),
    .inc    (inc_stb),
    .ptr    (ptr)
  );

  bp_bank_flag u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .lo       (sel_lo),
    .hi       (sel_hi),
    .qry      (qry_stb),
    .bank     (bank_act),
    .qry_vld  (qry_vld),
    .qry_bank (qry_bank)
  );

  assign addr_w   = {bank_act, ptr};
  assign arr_addr = addr_w;

  AST_BANK_STAYS_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_stb && !sel_lo && !sel_hi) |=> arr_addr[PTR_W] == $past(arr_addr[PTR_W])); // R7
  AST_BANK_AND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_stb && !ld_stb && sel_hi && !sel_lo) |=> arr_addr[PTR_W]); // R9
endmodule

// File: tb/sim_eeprom_bank_ptr.sv
`timescale 1ns/1ps
module sim_eeprom_bank_ptr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld_stb = 1'b0, inc_stb = 1'b0, sel_lo = 1'b0, sel_hi = 1'b0, qry_stb = 1'b0;
  logic [7:0] ld_val = '0;
  logic [8:0] arr_addr;
  logic       bank_act, qry_vld, qry_bank;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  eeprom_bank_ptr u0 (
    .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_val(ld_val), .inc_stb(inc_stb),
    .sel_lo(sel_lo), .sel_hi(sel_hi), .qry_stb(qry_stb),
    .arr_addr(arr_addr), .bank_act(bank_act), .qry_vld(qry_vld), .qry_bank(qry_bank)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // One clock edge, with inputs cleared after it and sampling 1 ns past it.
  task automatic step();
    @(posedge clk); #1;
    ld_stb = 0; inc_stb = 0; sel_lo = 0; sel_hi = 0; qry_stb = 0;
  endtask

  task automatic t_reset();
    #1; check("R1 addr in reset", 16'(arr_addr), 16'h000);
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    step();
    check("R1 addr", 16'(arr_addr), 16'h000);
    check("R1 bank", 16'(bank_act), 16'h0);
    check("R1 qry_vld", 16'(qry_vld), 16'h0);
  endtask

  task automatic t_inc();
    for (int i = 0; i < 3; i++) begin inc_stb = 1; step(); end
    check("R6 three increments", 16'(arr_addr), 16'h003);
    step();
    check("R10 idle hold", 16'(arr_addr), 16'h003);
  endtask

  task automatic t_load();
    ld_stb = 1; ld_val = 8'h5A; step();
    check("R8 load", 16'(arr_addr), 16'h05A);
    ld_stb = 1; ld_val = 8'h10; inc_stb = 1; step();
    check("R8 load beats inc", 16'(arr_addr), 16'h010);
  endtask

  task automatic t_bank();
    sel_hi = 1; step();
    check("R2 upper keeps pointer", 16'(arr_addr), 16'h110);
    check("R2 bank_act", 16'(bank_act), 16'h1);
    ld_stb = 1; ld_val = 8'h33; step();
    check("R8 load keeps bank", 16'(arr_addr), 16'h133);
    sel_lo = 1; sel_hi = 1; step();
    check("R4 both ignored", 16'(arr_addr), 16'h133);
    sel_lo = 1; step();
    check("R3 lower", 16'(arr_addr), 16'h033);
    sel_lo = 1; sel_hi = 1; step();
    check("R4 both ignored low", 16'(bank_act), 16'h0);
  endtask

  task automatic t_wrap();
    ld_stb = 1; ld_val = 8'hFE; step();
    inc_stb = 1; step();
    check("R7 reach top", 16'(arr_addr), 16'h0FF);
    inc_stb = 1; step();
    check("R7 wrap lower", 16'(arr_addr), 16'h000);
    sel_hi = 1; ld_stb = 1; ld_val = 8'hFF; step();
    check("R10 upper top", 16'(arr_addr), 16'h1FF);
    inc_stb = 1; step();
    check("R7 wrap upper", 16'(arr_addr), 16'h100);
  endtask

  task automatic t_query();
    qry_stb = 1; step();
    check("R5 vld", 16'(qry_vld), 16'h1);
    check("R5 bank upper", 16'(qry_bank), 16'h1);
    step();
    check("R5 single pulse", 16'(qry_vld), 16'h0);
    qry_stb = 1; sel_lo = 1; step();
    check("R5 same-cycle cmd vld", 16'(qry_vld), 16'h1);
    check("R5 same-cycle cmd bank", 16'(qry_bank), 16'h0);
  endtask

  task automatic t_mixed();
    ld_stb = 1; ld_val = 8'h40; step();
    sel_hi = 1; inc_stb = 1; step();
    check("R9 upper with inc", 16'(arr_addr), 16'h141);
    sel_lo = 1; inc_stb = 1; step();
    check("R9 lower with inc", 16'(arr_addr), 16'h042);
  endtask

  initial begin
    t_reset();
    t_inc();
    t_load();
    t_bank();
    t_wrap();
    t_query();
    t_mixed();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule